// File: doc/BRIEF.md
# Multiplexed Address/Data SRAM Glue

This block sits between a host with a narrow, shared bidirectional bus and an asynchronous SRAM twice as wide. Each access moves one word of two halves. The host first puts the low address bits on its bus and pulls an active-low address strobe. While the strobe stays low, the same pins then carry data. The block captures the address on the strobe's falling edge. Upper page bits travel on separate host lines, bypass every register and reach the SRAM address directly.

A copy of the address strobe, delayed by one glue-clock edge, does two jobs. It enables the SRAM output for reads, and it opens the low-half data register for writes. Because it is delayed, the SRAM output stays off during the address cycle, when the host still drives the bus.

On a write, the low half is held in the data register. The high half then passes through unregistered while the SRAM write strobe is low. The strobe is registered and cannot fall until at least one edge after the low half was captured. A write ends when the host releases both strobes together. On a read, the host turns its bus around after the address cycle and selects which SRAM half to fetch. It fetches the low half first and the high half second.

Top module: `adbus_sram_glue`

## Requirements
- R1: While reset is applied and after it is released, with the host strobes idle high, `sram_we_n` and `sram_oe_n` are 1, `sram_dq_oe` and `host_rd_en` are 0, and the low address bits are 0.
- R2: The low address bits load `host_bus_wr` at the first rising edge where `host_ale_n` is 0 and `sram_oe_n` is still 1. They then hold while `host_ale_n` stays low, whatever the bus carries.
- R3: `sram_addr[HALF_W+PAGE_W-1:HALF_W]` follows `host_page` in the same cycle, with no register.
- R4: `sram_oe_n` equals `host_ale_n` delayed by one rising edge, so it is 1 in the cycle the address strobe first goes low.
- R5: `sram_dq_out[HALF_W-1:0]` loads `host_bus_wr` at edges where `host_ale_n` and `sram_oe_n` are 0 and `host_we_n` is 1. It holds while `host_we_n` is 0.
- R6: `sram_dq_out[2*HALF_W-1:HALF_W]` equals `host_bus_wr` combinationally.
- R7: `sram_we_n` falls only after an edge where `host_we_n`, `host_ale_n` and `sram_oe_n` are 0 and a low-half capture happened at an earlier edge of the same access. A write strobe given in the first data cycle therefore never reaches the SRAM.
- R8: An edge with `host_ale_n` and `host_we_n` both 1 leaves `sram_we_n` and `sram_oe_n` both 1.
- R9: `sram_dq_oe` is 1 exactly while `sram_we_n` is 0.
- R10: `host_bus_rd` is `sram_dq_in[15:0]` when `host_hsel` is 0 and `sram_dq_in[31:16]` when it is 1. `host_rd_en` is 1 only when `sram_oe_n` is 0, `sram_we_n` is 1 and `host_drv` is 0.
- R11: Raising `host_ale_n` ends the access. The next falling edge of the strobe captures a new address, and a new low-half capture is needed before the next write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Glue clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_ale_n | input | 1 | Address strobe, active low, idles high |
| host_we_n | input | 1 | Write request, active low, idles high |
| host_drv | input | 1 | 1 while the host drives its bus |
| host_hsel | input | 1 | Read half select: 0 low, 1 high |
| host_bus_wr | input | HALF_W | Value the host drives on the shared bus |
| host_page | input | PAGE_W | Unlatched upper page address bits |
| host_bus_rd | output | HALF_W | Read half returned to the host |
| host_rd_en | output | 1 | Block may drive the host bus |
| sram_addr | output | HALF_W+PAGE_W | SRAM address |
| sram_dq_out | output | 2*HALF_W | SRAM write data |
| sram_dq_oe | output | 1 | Block drives the SRAM data lines |
| sram_dq_in | input | 2*HALF_W | SRAM read data |
| sram_oe_n | output | 1 | SRAM output enable, active low |
| sram_we_n | output | 1 | SRAM write enable, active low |

## Verification
The bound properties check, on every cycle, that the output enable tracks the delayed strobe and that the address stays fixed once captured. They also check that the low write half is frozen while the SRAM write strobe is low, that the write strobe never falls without a preceding held write request inside an access, and that releasing both strobes closes the access. Only the bench's scenarios show the rest. These are the actual address and data values reaching the SRAM, the blocked write when the request comes too early, the selection of read halves, the immediate page pass-through, and the fact that neither side drives a bus the other one owns.

// File: rtl/adsg_pkg.sv
package adsg_pkg;
  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } half_sel_e;
endpackage

// File: rtl/adsg_rst_sync.sv
module adsg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_q_n = sync_q[1];
endmodule

// File: rtl/adsg_strobe_gen.sv
module adsg_strobe_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic ale_n,
  input  logic host_we_n,
  input  logic data_held,
  output logic dle_n,
  output logic sram_we_n,
  output logic addr_load,
  output logic data_load
);
  logic dle_d;
  logic we_d;

  always_comb begin
    addr_load = ~ale_n & dle_n;
    data_load = ~ale_n & ~dle_n & host_we_n;
    dle_d     = ale_n;
    we_d      = ~(~host_we_n & ~ale_n & ~dle_n & data_held);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dle_n     <= 1'b1;
      sram_we_n <= 1'b1;
    end else begin
      dle_n     <= dle_d;
      sram_we_n <= we_d;
    end
  end
endmodule

// File: rtl/adsg_addr_latch.sv
module adsg_addr_latch #(
  parameter int HALF_W = 16,
  parameter int PAGE_W = 3,
  localparam int ADDR_W = HALF_W + PAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_load,
  input  logic [HALF_W-1:0] bus,
  input  logic [PAGE_W-1:0] page,
  output logic [ADDR_W-1:0] sram_addr
);
  logic [HALF_W-1:0] addr_q;
  logic [HALF_W-1:0] addr_d;

  always_comb addr_d = addr_load ? bus : addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end

  assign sram_addr = {page, addr_q};
endmodule

// File: rtl/adsg_wdata_path.sv
module adsg_wdata_path #(
  parameter int HALF_W = 16,
  localparam int WORD_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ale_n,
  input  logic              data_load,
  input  logic              sram_we_n,
  input  logic [HALF_W-1:0] bus,
  output logic              data_held,
  output logic [WORD_W-1:0] sram_dq_out,
  output logic              sram_dq_oe
);
  logic [HALF_W-1:0] lo_q;
  logic [HALF_W-1:0] lo_d;
  logic              held_d;

  always_comb begin
    lo_d = data_load ? bus : lo_q;
    if (ale_n)          held_d = 1'b0;
    else if (data_load) held_d = 1'b1;
    else                held_d = data_held;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q      <= '0;
      data_held <= 1'b0;
    end else begin
      lo_q      <= lo_d;
      data_held <= held_d;
    end
  end

  assign sram_dq_out = {bus, lo_q};
  assign sram_dq_oe  = ~sram_we_n;
endmodule

// File: rtl/adsg_read_mux.sv
module adsg_read_mux
  import adsg_pkg::*;
#(
  parameter int HALF_W = 16,
  localparam int WORD_W = 2 * HALF_W
) (
  input  logic              hsel,
  input  logic              host_drv,
  input  logic              sram_oe_n,
  input  logic              sram_we_n,
  input  logic [WORD_W-1:0] sram_dq_in,
  output logic [HALF_W-1:0] host_bus_rd,
  output logic              host_rd_en
);
  half_sel_e sel;

  always_comb begin
    sel         = half_sel_e'(hsel);
    host_bus_rd = (sel == HALF_HI) ? sram_dq_in[WORD_W-1:HALF_W]
                                   : sram_dq_in[HALF_W-1:0];
    host_rd_en  = ~sram_oe_n & sram_we_n & ~host_drv;
  end
endmodule

// File: rtl/adbus_sram_glue.sv
module adbus_sram_glue #(
  parameter int HALF_W = 16,
  parameter int PAGE_W = 3,
  localparam int ADDR_W = HALF_W + PAGE_W,
  localparam int WORD_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_ale_n,
  input  logic              host_we_n,
  input  logic              host_drv,
  input  logic              host_hsel,
  input  logic [HALF_W-1:0] host_bus_wr,
  input  logic [PAGE_W-1:0] host_page,
  output logic [HALF_W-1:0] host_bus_rd,
  output logic              host_rd_en,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [WORD_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  input  logic [WORD_W-1:0] sram_dq_in,
  output logic              sram_oe_n,
  output logic              sram_we_n
);
  logic rst_q_n;
  logic dle_n;
  logic addr_load;
  logic data_load;
  logic data_held;

  adsg_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  adsg_strobe_gen u_strobe (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .ale_n     (host_ale_n),
    .host_we_n (host_we_n),
    .data_held (data_held),
    .dle_n     (dle_n),
    .sram_we_n (sram_we_n),
    .addr_load (addr_load),
    .data_load (data_load)
  );

  adsg_addr_latch #(.HALF_W(HALF_W), .PAGE_W(PAGE_W)) u_addr (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .addr_load (addr_load),
    .bus       (host_bus_wr),
    .page      (host_page),
    .sram_addr (sram_addr)
  );

  adsg_wdata_path #(.HALF_W(HALF_W)) u_wdata (
    .clk         (clk),
    .rst_n       (rst_q_n),
    .ale_n       (host_ale_n),
    .data_load   (data_load),
    .sram_we_n   (sram_we_n),
    .bus         (host_bus_wr),
    .data_held   (data_held),
    .sram_dq_out (sram_dq_out),
    .sram_dq_oe  (sram_dq_oe)
  );

  adsg_read_mux #(.HALF_W(HALF_W)) u_rmux (
    .hsel        (host_hsel),
    .host_drv    (host_drv),
    .sram_oe_n   (dle_n),
    .sram_we_n   (sram_we_n),
    .sram_dq_in  (sram_dq_in),
    .host_bus_rd (host_bus_rd),
    .host_rd_en  (host_rd_en)
  );

  assign sram_oe_n = dle_n;
endmodule

// File: rtl/adsg_checker.sv
module adsg_checker #(
  parameter int HALF_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ale_n,
  input logic              host_we_n,
  input logic [HALF_W-1:0] addr_lo,
  input logic [HALF_W-1:0] dq_lo,
  input logic              sram_oe_n,
  input logic              sram_we_n
);
  assert_oe_delay_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sram_oe_n == $past(ale_n));

  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ale_n && !sram_oe_n) |=> $stable(addr_lo));

  assert_lo_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> $stable(dq_lo));

  assert_we_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sram_we_n) |-> ($past(!host_we_n) && $past(!sram_oe_n)));

  assert_we_in_access_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> !sram_oe_n);

  assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ale_n && host_we_n) |=> (sram_oe_n && sram_we_n));
endmodule

bind adbus_sram_glue adsg_checker #(.HALF_W(HALF_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_q_n),
  .ale_n     (host_ale_n),
  .host_we_n (host_we_n),
  .addr_lo   (sram_addr[HALF_W-1:0]),
  .dq_lo     (sram_dq_out[HALF_W-1:0]),
  .sram_oe_n (sram_oe_n),
  .sram_we_n (sram_we_n)
);

// File: tb/adbus_sram_glue_bench.sv
module adbus_sram_glue_bench;
  localparam int H  = 16;
  localparam int P  = 3;
  localparam int AW = H + P;
  localparam int WW = 2 * H;
  localparam int NV = 6;

  // page, address, write word
  localparam logic [P+H+WW-1:0] VEC [NV] = '{
    {3'd0, 16'h0000, 32'h1234_5678},
    {3'd1, 16'hFFFF, 32'hDEAD_BEEF},
    {3'd7, 16'h8001, 32'h0000_FFFF},
    {3'd2, 16'h5AA5, 32'hFFFF_0000},
    {3'd5, 16'h7FFE, 32'hA5A5_5A5A},
    {3'd3, 16'h0100, 32'h0F0F_F0F0}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          host_ale_n, host_we_n, host_drv, host_hsel;
  logic [H-1:0]  host_bus_wr;
  logic [P-1:0]  host_page;
  logic [H-1:0]  host_bus_rd;
  logic          host_rd_en;
  logic [AW-1:0] sram_addr;
  logic [WW-1:0] sram_dq_out;
  logic          sram_dq_oe;
  logic [WW-1:0] sram_dq_in;
  logic          sram_oe_n, sram_we_n;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  mon_on = 1'b0;
  bit  done   = 1'b0;

  always #2.5 clk = ~clk;

  adbus_sram_glue #(.HALF_W(H), .PAGE_W(P)) u_adbus_sram_glue (
    .clk(clk), .rst_n(rst_n), .host_ale_n(host_ale_n), .host_we_n(host_we_n),
    .host_drv(host_drv), .host_hsel(host_hsel), .host_bus_wr(host_bus_wr),
    .host_page(host_page), .host_bus_rd(host_bus_rd), .host_rd_en(host_rd_en),
    .sram_addr(sram_addr), .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe),
    .sram_dq_in(sram_dq_in), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n)
  );

  function automatic logic [WW-1:0] mem_of(input logic [AW-1:0] a);
    return {a[H-1:0] ^ 16'h3C5A ^ {13'd0, a[AW-1:H]}, ~a[H-1:0]};
  endfunction

  // SRAM model: drives only with output enabled and no write strobe
  logic model_drv;
  always_comb begin
    model_drv  = !sram_oe_n && sram_we_n;
    sram_dq_in = model_drv ? mem_of(sram_addr) : '0;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  // bus ownership monitor, sampled between edges
  always @(negedge clk) begin
    #2;
    if (mon_on) begin
      chk("R10 sram-side contention", {63'd0, model_drv && sram_dq_oe}, 64'd0);
      chk("R10 host-side contention", {63'd0, host_rd_en && host_drv}, 64'd0);
    end
  end

  task automatic do_write(input logic [P-1:0] pg, input logic [H-1:0] a,
                          input logic [WW-1:0] d, input string rtag);
    host_bus_wr = a; host_page = pg; host_ale_n = 1'b0; host_drv = 1'b1;
    #1 chk("R4 oe off in address cycle", {63'd0, sram_oe_n}, 64'd1);
    tick;
    chk(rtag, {45'd0, sram_addr}, {45'd0, pg, a});
    chk("R4 oe follows strobe", {63'd0, sram_oe_n}, 64'd0);
    host_bus_wr = d[H-1:0];
    tick;
    chk("R5 low half captured", {48'd0, sram_dq_out[H-1:0]}, {48'd0, d[H-1:0]});
    chk("R7 no strobe before request", {63'd0, sram_we_n}, 64'd1);
    chk("R2 address held", {48'd0, sram_addr[H-1:0]}, {48'd0, a});
    host_bus_wr = d[WW-1:H]; host_we_n = 1'b0;
    #1 chk("R6 high half passes", {48'd0, sram_dq_out[WW-1:H]}, {48'd0, d[WW-1:H]});
    tick;
    chk("R7 write strobe low", {63'd0, sram_we_n}, 64'd0);
    chk("R9 data drive on", {63'd0, sram_dq_oe}, 64'd1);
    chk("R6 full word at SRAM", {32'd0, sram_dq_out}, {32'd0, d});
    chk("R2 address at write", {45'd0, sram_addr}, {45'd0, pg, a});
    host_bus_wr = ~d[WW-1:H];
    tick;
    chk("R5 low half frozen", {48'd0, sram_dq_out[H-1:0]}, {48'd0, d[H-1:0]});
    chk("R6 high half tracks bus", {48'd0, sram_dq_out[WW-1:H]}, {48'd0, ~d[WW-1:H]});
    host_ale_n = 1'b1; host_we_n = 1'b1;
    tick;
    chk("R8 strobes released", {62'd0, sram_we_n, sram_oe_n}, 64'd3);
    chk("R9 data drive off", {63'd0, sram_dq_oe}, 64'd0);
  endtask

  task automatic do_read(input logic [P-1:0] pg, input logic [H-1:0] a);
    logic [WW-1:0] w;
    host_bus_wr = a; host_page = pg; host_ale_n = 1'b0; host_drv = 1'b1;
    tick;
    host_drv = 1'b0; host_hsel = 1'b0;
    w = mem_of({pg, a});
    #1 chk("R10 read enable", {63'd0, host_rd_en}, 64'd1);
    chk("R10 low half first", {48'd0, host_bus_rd}, {48'd0, w[H-1:0]});
    host_hsel = 1'b1;
    #1 chk("R10 high half second", {48'd0, host_bus_rd}, {48'd0, w[WW-1:H]});
    host_page = ~pg;
    #1 chk("R3 page passes at once", {61'd0, sram_addr[AW-1:H]}, {61'd0, ~pg});
    host_page = pg;
    tick;
    host_ale_n = 1'b1; host_drv = 1'b1; host_hsel = 1'b0;
    tick;
    chk("R10 read enable off", {63'd0, host_rd_en}, 64'd0);
    chk("R8 oe released after read", {63'd0, sram_oe_n}, 64'd1);
  endtask

  initial begin
    rst_n = 1'b0; host_ale_n = 1'b1; host_we_n = 1'b1; host_drv = 1'b1;
    host_hsel = 1'b0; host_bus_wr = '0; host_page = '0;
    repeat (3) tick;
    chk("R1 reset we", {63'd0, sram_we_n}, 64'd1);
    chk("R1 reset oe", {63'd0, sram_oe_n}, 64'd1);
    chk("R1 reset drive", {62'd0, sram_dq_oe, host_rd_en}, 64'd0);
    chk("R1 reset address", {48'd0, sram_addr[H-1:0]}, 64'd0);
    rst_n = 1'b1;
    repeat (4) tick;
    chk("R1 idle after reset", {62'd0, sram_we_n, sram_oe_n}, 64'd3);
    mon_on = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [P+H+WW-1:0] v;
      v = VEC[i];
      do_write(v[P+H+WW-1:H+WW], v[H+WW-1:WW], v[WW-1:0],
               (i == 0) ? "R2 address captured" : "R11 next access address");
      do_read(v[P+H+WW-1:H+WW], v[H+WW-1:WW]);
    end

    // R7 corner: write request in the first data cycle is refused
    host_bus_wr = 16'h4321; host_page = 3'd6; host_ale_n = 1'b0;
    tick;
    host_bus_wr = 16'h9999; host_we_n = 1'b0;
    tick;
    chk("R7 early request blocked", {63'd0, sram_we_n}, 64'd1);
    tick;
    chk("R7 still blocked", {63'd0, sram_we_n}, 64'd1);
    chk("R9 no drive when blocked", {63'd0, sram_dq_oe}, 64'd0);
    host_ale_n = 1'b1; host_we_n = 1'b1;
    tick;
    chk("R8 released after blocked", {62'd0, sram_we_n, sram_oe_n}, 64'd3);

    // R11: a fresh access after release captures a new address
    host_bus_wr = 16'hBEEF; host_ale_n = 1'b0;
    tick;
    chk("R11 new capture", {48'd0, sram_addr[H-1:0]}, {48'd0, 16'hBEEF});
    host_ale_n = 1'b1;
    tick;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule